// File: doc/BRIEF.md
# Framebuffer Scan Address Generator

This block is the memory-read half of a fixed-geometry true-colour display pipeline. A host programs two word-indexed registers: a framebuffer base pointer and a control word. The control word switches the display on and can turn the picture upside down. The block walks the visible raster one pixel at a time. For each pixel it issues a single read of one 32-bit word and splits the returned word into 8-bit red, green and blue values, qualified by a valid strobe.

Line and frame start pulses come from an external timing generator. The memory system answers each read with a one-cycle data-valid pulse. Register values written by the host are captured into shadow copies only on a frame-start pulse, so a picture never mixes two configurations. By default the block scans 640 pixels by 480 lines with a 1024-word line stride, and the base pointer is aligned to 2 MiB.

Top module: `fb_scan_gen`

## Requirements
- R1: Register index 0 is the base pointer and index 1 is the control word. A write with `reg_wr` high stores `reg_wdata` into the indexed register. `reg_rdata` always shows the register selected by `reg_idx`.
- R2: The base register keeps only the upper 11 of its 32 bits and reads back with bits 20:0 as zero. Fetch addresses start from this 2 MiB-aligned value.
- R3: Control bit 0 is the enable bit. During a frame that started with this bit clear, no request is issued and the colour outputs stay zero. Control bits 31:2 read back as zero.
- R4: Control bit 1 is the rotate bit. When it is set, pixel (x, y) is fetched from the word of pixel (H-1-x, V-1-y).
- R5: The byte address of pixel (x, y) is base + ((y*PITCH + x) << 2), and requests are issued in raster order. Words H to PITCH-1 of a line are never requested.
- R6: Each returned word is split so that red is bits 23:16, green is bits 15:8 and blue is bits 7:0. Bits 31:24 have no effect on the outputs.
- R7: Register writes affect fetching only from the next `frame_start` pulse onward.
- R8: At most one read is outstanding. A new request appears only after the data for the previous one has returned.
- R9: `frame_start` returns the scan to pixel (0, 0). Each `line_start` pulse then fetches one line of H pixels. An enabled frame issues exactly H*V requests and produces H*V pixels.
- R10: After reset both registers read zero, the display is disabled, and `mem_req` and `pix_valid` are low.
- R11: `pix_valid` rises the cycle after an accepted data return. Whenever `pix_valid` is low, the colour outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 1 | Register word index (0 base, 1 control) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the indexed register |
| frame_start | input | 1 | Frame start pulse |
| line_start | input | 1 | Line start pulse |
| mem_req | output | 1 | Read request, one cycle per fetch |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| pix_valid | output | 1 | Pixel output valid |
| pix_red | output | 8 | Red level |
| pix_green | output | 8 | Green level |
| pix_blue | output | 8 | Blue level |

## Verification
The bench builds the block with an 8-pixel by 4-line raster and a 16-word line stride, keeping the 32-bit address and the 11-bit base field. The short raster makes many whole frames affordable: normal, rotated, disabled and deferred-configuration frames each run to completion several times. Every line-end and frame-end wrap and every rotated corner address therefore comes up repeatedly. Random memory latencies and random base values exercise the single-outstanding handshake and the alignment of the base field.

// File: rtl/fb_scan_pkg.sv
package fb_scan_pkg;

    localparam int unsigned REG_W     = 32;
    localparam int unsigned CH_W      = 8;
    localparam logic        IDX_BASE  = 1'b0;
    localparam logic        IDX_CTRL  = 1'b1;
    localparam int unsigned CTRL_EN   = 0;
    localparam int unsigned CTRL_ROT  = 1;

    typedef struct packed {
        logic [CH_W-1:0] red;
        logic [CH_W-1:0] green;
        logic [CH_W-1:0] blue;
    } rgb_t;

    typedef struct packed {
        logic en;
        logic rot;
    } ctrl_t;

    // Split a memory word into colour channels; the top byte is dropped.
    function automatic rgb_t split_word(input logic [REG_W-1:0] w);
        rgb_t p;
        p.red   = w[23:16];
        p.green = w[15:8];
        p.blue  = w[7:0];
        return p;
    endfunction

endpackage

// File: rtl/fb_cfg_regs.sv
module fb_cfg_regs
    import fb_scan_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned BASE_BITS = 11
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr,
    input  logic                 idx,
    input  logic [REG_W-1:0]     wdata,
    output logic [REG_W-1:0]     rdata,
    input  logic                 frame_start,
    output logic [BASE_BITS-1:0] sh_base,
    output ctrl_t                sh_ctrl
);
    localparam int unsigned LSB = ADDR_W - BASE_BITS;

    logic [BASE_BITS-1:0] base_q;
    ctrl_t                ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            ctrl_q  <= '0;
            sh_base <= '0;
            sh_ctrl <= '0;
        end else begin
            if (wr && idx == IDX_BASE) base_q <= wdata[ADDR_W-1:LSB];
            if (wr && idx == IDX_CTRL) begin
                ctrl_q.en  <= wdata[CTRL_EN];
                ctrl_q.rot <= wdata[CTRL_ROT];
            end
            if (frame_start) begin
                sh_base <= base_q;
                sh_ctrl <= ctrl_q;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (idx == IDX_BASE) rdata[ADDR_W-1:LSB] = base_q;
        else begin
            rdata[CTRL_EN]  = ctrl_q.en;
            rdata[CTRL_ROT] = ctrl_q.rot;
        end
    end

    // R7
    shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(frame_start) |-> ($stable(sh_base) && $stable(sh_ctrl)));
endmodule

// File: rtl/fb_scan_ctr.sv
module fb_scan_ctr
    import fb_scan_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned BASE_BITS = 11,
    parameter int unsigned H_PIX     = 640,
    parameter int unsigned V_LINES   = 480,
    parameter int unsigned PITCH     = 1024
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_start,
    input  logic                 line_start,
    input  logic [BASE_BITS-1:0] sh_base,
    input  ctrl_t                sh_ctrl,
    output logic                 mem_req,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic                 mem_rvalid,
    output logic                 accept
);
    localparam int unsigned LSB = ADDR_W - BASE_BITS;
    localparam int unsigned XW  = (H_PIX > 1) ? $clog2(H_PIX) : 1;
    localparam int unsigned YW  = $clog2(V_LINES + 1);
    localparam int unsigned PW  = $clog2(PITCH);

    logic [XW-1:0] x_q;
    logic [YW-1:0] y_q;
    logic          armed_q, active_q, pend_q, stale_q;

    assign mem_req = active_q && !pend_q && sh_ctrl.en;
    assign accept  = mem_rvalid && pend_q && !stale_q && active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q <= '0; y_q <= '0;
            armed_q <= 1'b0; active_q <= 1'b0;
            pend_q <= 1'b0; stale_q <= 1'b0;
        end else begin
            if (mem_rvalid) begin
                pend_q  <= 1'b0;
                stale_q <= 1'b0;
            end
            if (mem_req) pend_q <= 1'b1;
            if (frame_start) begin
                x_q      <= '0;
                y_q      <= '0;
                armed_q  <= 1'b1;
                active_q <= 1'b0;
                stale_q  <= pend_q && !mem_rvalid;
            end else begin
                if (line_start && armed_q && !active_q) begin
                    active_q <= 1'b1;
                    x_q      <= '0;
                end
                if (accept) begin
                    if (x_q == XW'(H_PIX - 1)) begin
                        x_q      <= '0;
                        active_q <= 1'b0;
                        y_q      <= y_q + 1'b1;
                        if (y_q == YW'(V_LINES - 1)) armed_q <= 1'b0;
                    end else begin
                        x_q <= x_q + 1'b1;
                    end
                end
            end
        end
    end

    logic [ADDR_W-1:0] row_w, col_w, word_off, base_full;
    always_comb begin
        row_w     = sh_ctrl.rot ? ADDR_W'(V_LINES - 1) - ADDR_W'(y_q) : ADDR_W'(y_q);
        col_w     = sh_ctrl.rot ? ADDR_W'(H_PIX - 1) - ADDR_W'(x_q) : ADDR_W'(x_q);
        word_off  = row_w * ADDR_W'(PITCH) + col_w;
        base_full = {sh_base, {LSB{1'b0}}};
        mem_addr  = base_full + (word_off << 2);
    end

    // R8
    one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);
    // R5
    col_range_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[2 +: PW] < PW'(H_PIX)));
    // R9
    x_bound_chk: assert property (@(posedge clk) disable iff (rst)
        ADDR_W'(x_q) < ADDR_W'(H_PIX));
endmodule

// File: rtl/fb_pix_out.sv
module fb_pix_out
    import fb_scan_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [REG_W-1:0] rdata,
    output logic             pix_valid,
    output rgb_t             pix
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pix_valid <= 1'b0;
            pix       <= '0;
        end else begin
            pix_valid <= accept;
            pix       <= accept ? split_word(rdata) : '0;
        end
    end

    // R11
    blank_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |-> (pix == '0));
    // R11
    valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> $past(accept));
endmodule

// File: rtl/fb_scan_gen.sv
module fb_scan_gen
    import fb_scan_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned BASE_BITS = 11,
    parameter int unsigned H_PIX     = 640,
    parameter int unsigned V_LINES   = 480,
    parameter int unsigned PITCH     = 1024
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_idx,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        frame_start,
    input  logic        line_start,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    output logic        pix_valid,
    output logic [7:0]  pix_red,
    output logic [7:0]  pix_green,
    output logic [7:0]  pix_blue
);
    logic [BASE_BITS-1:0] sh_base;
    ctrl_t                sh_ctrl;
    logic                 accept;
    rgb_t                 pix;

    fb_cfg_regs #(.ADDR_W(ADDR_W), .BASE_BITS(BASE_BITS)) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .idx(reg_idx), .wdata(reg_wdata),
        .rdata(reg_rdata), .frame_start(frame_start),
        .sh_base(sh_base), .sh_ctrl(sh_ctrl)
    );

    fb_scan_ctr #(.ADDR_W(ADDR_W), .BASE_BITS(BASE_BITS), .H_PIX(H_PIX),
                  .V_LINES(V_LINES), .PITCH(PITCH)) u_scan (
        .clk(clk), .rst(rst), .frame_start(frame_start), .line_start(line_start),
        .sh_base(sh_base), .sh_ctrl(sh_ctrl), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .accept(accept)
    );

    fb_pix_out u_out (
        .clk(clk), .rst(rst), .accept(accept), .rdata(mem_rdata),
        .pix_valid(pix_valid), .pix(pix)
    );

    assign pix_red   = pix.red;
    assign pix_green = pix.green;
    assign pix_blue  = pix.blue;

    // R3
    quiet_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !sh_ctrl.en |=> !pix_valid);
endmodule

// File: tb/fb_scan_gen_test.sv
module fb_scan_gen_test;
    localparam int H = 8, V = 4, P = 16;

    logic clk = 1'b0, rst = 1'b1;
    logic reg_wr = 0, reg_idx = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic frame_start = 0, line_start = 0;
    logic mem_req, mem_rvalid = 0;
    logic [31:0] mem_addr, mem_rdata = 0;
    logic pix_valid;
    logic [7:0] pix_red, pix_green, pix_blue;

    fb_scan_gen #(.ADDR_W(32), .BASE_BITS(11), .H_PIX(H), .V_LINES(V), .PITCH(P)) uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .frame_start(frame_start), .line_start(line_start),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .pix_valid(pix_valid), .pix_red(pix_red),
        .pix_green(pix_green), .pix_blue(pix_blue)
    );

    always #2 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] data_of(input logic [31:0] a);
        return {a[7:0] ^ 8'h5A, a[7:0] ^ 8'h3C, a[9:2], a[11:4] + 8'h11};
    endfunction

    function automatic logic [31:0] exp_addr(input logic [31:0] b, input bit rot, input int x, input int y);
        int r, c;
        r = rot ? V - 1 - y : y;
        c = rot ? H - 1 - x : x;
        return (b & 32'hFFE0_0000) + 32'((r * P + c) << 2);
    endfunction

    logic [31:0] cur_base = 0, cur_ctrl = 0, mon_base = 0;
    bit mon_en = 0, mon_rot = 0;
    int mx = 0, my = 0, fetch_cnt = 0, pix_cnt = 0;
    bit mp_pend = 0;
    int mp_cnt = 0;
    logic [31:0] mp_addr = 0;
    logic [31:0] expq[$];

    always @(negedge clk) begin
        if (!rst) begin
            mem_rvalid = 1'b0;
            if (mp_pend) begin
                if (mp_cnt == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = data_of(mp_addr);
                    mp_pend    = 0;
                end else mp_cnt--;
            end
            if (pix_valid) begin
                logic [31:0] w;
                w = (expq.size() > 0) ? expq.pop_front() : 32'hDEAD_BEEF;
                // R6: red 23:16, green 15:8, blue 7:0, top byte dropped
                chk({pix_red, pix_green, pix_blue} == w[23:0], "R6",
                    {8'h0, pix_red, pix_green, pix_blue}, {8'h0, w[23:0]});
                pix_cnt++;
            end else begin
                // R11 / R3: colours zero while not valid
                chk({pix_red, pix_green, pix_blue} == 24'h0, "R11",
                    {8'h0, pix_red, pix_green, pix_blue}, 32'h0);
            end
            if (mem_req) begin
                logic [31:0] ea;
                chk(!mp_pend, "R8", 32'(mp_pend), 32'h0);
                chk(mon_en, "R3/R7 request while disabled", 32'(mem_req), 32'h0);
                ea = exp_addr(mon_base, mon_rot, mx, my);
                chk(mem_addr == ea, mon_rot ? "R4" : "R5", mem_addr, ea);
                expq.push_back(data_of(mem_addr));
                fetch_cnt++;
                mx++;
                if (mx == H) begin mx = 0; my++; end
                mp_pend = 1;
                mp_addr = mem_addr;
                mp_cnt  = $urandom % 4;
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic idx, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
        if (idx) cur_ctrl = d; else cur_base = d;
    endtask

    task automatic rd_chk(input logic idx, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_idx = idx;
        #1;
        chk(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    // Runs one frame; optional ctrl write in the middle of it (R7).
    task automatic run_frame(input bit mid_wr, input logic [31:0] mid_val);
        int exp_n;
        @(negedge clk);
        mon_base = cur_base; mon_en = cur_ctrl[0]; mon_rot = cur_ctrl[1];
        mx = 0; my = 0; fetch_cnt = 0; pix_cnt = 0;
        frame_start = 1;
        @(negedge clk);
        frame_start = 0;
        for (int l = 0; l < V; l++) begin
            cyc(2);
            line_start = 1;
            @(negedge clk);
            line_start = 0;
            if (mid_wr && l == 1) wr_reg(1'b1, mid_val);
            cyc(60);
        end
        cyc(8);
        exp_n = mon_en ? H * V : 0;
        // R9: whole frame fetched and delivered
        chk(fetch_cnt == exp_n, "R9 fetches", 32'(fetch_cnt), 32'(exp_n));
        chk(pix_cnt == exp_n, "R9 pixels", 32'(pix_cnt), 32'(exp_n));
        chk(expq.size() == 0, "R11 pending pixels", 32'(expq.size()), 32'h0);
    endtask

    initial begin
        void'($urandom(32'h1234_5678));
        cyc(4);
        rst = 0;
        cyc(2);
        // R10: reset state
        chk(mem_req == 0 && pix_valid == 0, "R10 outputs", {30'h0, mem_req, pix_valid}, 32'h0);
        rd_chk(1'b0, 32'h0, "R10 base");
        rd_chk(1'b1, 32'h0, "R10 ctrl");
        // R10: display off after reset, frame produces nothing
        run_frame(0, 0);

        // R1 / R2 / R3: register map and readback masking
        wr_reg(1'b0, 32'hFFFF_FFFF);
        rd_chk(1'b0, 32'hFFE0_0000, "R2");
        wr_reg(1'b1, 32'hFFFF_FFFC);
        rd_chk(1'b1, 32'h0000_0000, "R3 unused ctrl bits");
        wr_reg(1'b1, 32'h0000_0003);
        rd_chk(1'b1, 32'h0000_0003, "R1 ctrl");
        rd_chk(1'b0, 32'hFFE0_0000, "R1 base kept");
        wr_reg(1'b0, 32'h1234_5678);
        rd_chk(1'b0, 32'h1220_0000, "R2 low bits");

        // Directed: plain scan, then rotated scan (R5, R4)
        wr_reg(1'b1, 32'h1);
        run_frame(0, 0);
        wr_reg(1'b1, 32'h3);
        run_frame(0, 0);

        // R7: enable written mid-frame of a disabled frame is deferred
        wr_reg(1'b1, 32'h0);
        run_frame(0, 0);
        run_frame(1, 32'h1);
        run_frame(0, 0);
        // R7: disable written mid-frame of an enabled frame is deferred
        run_frame(1, 32'h0);
        run_frame(0, 0);

        // Random frames
        for (int k = 0; k < 20; k++) begin
            wr_reg(1'b0, $urandom);
            wr_reg(1'b1, 32'($urandom % 4));
            run_frame(0, 0);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule